// File: doc/BRIEF.md
# Watchpoint and Breakpoint Event Combiner

This block sits between the debug comparators of a processor core and the trap logic. Raw comparator hits are turned into named debug events by two programmable AND-OR stages in series. The first stage works on the four instruction-address comparator hits of a fetched instruction. It forms four instruction watchpoints and one instruction breakpoint. The second stage works on those four instruction watchpoints together with the four load/store comparator hits of the same instruction. It forms two load/store watchpoints and one load/store breakpoint. An instruction watchpoint can therefore qualify a data access, for example "this store, but only from that routine".

Events are not issued when they are detected. Each in-flight instruction carries a tag. The first-stage result is parked in a small pending table under that tag at fetch, and load/store hits are ORed into the same entry as the accesses occur. The second stage is evaluated only when the tag retires. A flush discards the entries of every instruction younger than the flush point, so squashed instructions never report. Breakpoints are further gated at retirement by a per-breakpoint trap enable and a per-breakpoint masking mode. Both can be changed while the core runs. Three instruction watchpoints and both load/store watchpoints also appear on a five-bit external pin bus. The block has no ready or stall signal, so it cannot disturb pipeline timing.

Top module: `wp_combiner`

## Requirements
- R1: After reset, every event output and every pin is 0.
- R2: First stage: output o (0..3 = instruction watchpoint 0..3, 4 = instruction breakpoint) is the OR of two terms. Term t of output o is the AND of the instruction hits `i` whose select bit `s1_sel[(o*2+t)*4+i]` is set. A term with no select bit set never fires. The first stage uses `s1_sel` and `icmp_hit` as they are in the fetch cycle.
- R3: Second stage: output o (0,1 = load/store watchpoint 0,1; 2 = load/store breakpoint) is formed the same way from `s2_sel[(o*2+t)*8+i]`. Input index i is 0..3 for the stored instruction watchpoints and 4..7 for load/store hits 0..3. The second stage uses `s2_sel` as it is in the retire cycle.
- R4: Events appear only in the cycle after a retire strobe for a tag holding a live entry, as one-cycle pulses. In every other cycle all outputs are 0, including fetch and load/store cycles.
- R5: Load/store hits for a tag accumulate by OR over all its accesses between fetch and retire. This includes an access presented in the retire cycle itself.
- R6: A flush naming tag F invalidates every entry whose age relative to the oldest unretired tag is greater than the age of F. Such tags later retire with no event. A new fetch of the same tag creates a live entry again.
- R7: `ibrk` requires `trap_en[0]` and `lbrk` requires `trap_en[1]`, sampled in the retire cycle. A change between fetch and retire takes effect.
- R8: When `brk_nomask[k]` is 0, breakpoint k (0 = instruction, 1 = load/store) fires only if `core_unmasked` is 1 in the retire cycle. When `brk_nomask[k]` is 1, `core_unmasked` is ignored.
- R9: `wp_pin[2:0]` equals `iwp_evt[2:0]` and `wp_pin[4:3]` equals `lwp_evt[1:0]`.
- R10: Watchpoint outputs do not depend on `trap_en`, `brk_nomask` or `core_unmasked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| s1_sel | input | 40 | First-stage term select bits |
| s2_sel | input | 48 | Second-stage term select bits |
| trap_en | input | 2 | Trap enables: bit 0 instruction, bit 1 load/store breakpoint |
| brk_nomask | input | 2 | 1 = breakpoint is nonmasked, 0 = masked |
| core_unmasked | input | 1 | Core currently accepts masked breakpoints |
| fetch_vld | input | 1 | Instruction fetched with tag `fetch_tag` |
| fetch_tag | input | 3 | Tag of the fetched instruction |
| icmp_hit | input | 4 | Instruction comparator hits for the fetch |
| ls_vld | input | 1 | Load/store bus cycle for tag `ls_tag` |
| ls_tag | input | 3 | Tag of the load/store instruction |
| lcmp_hit | input | 4 | Load/store comparator hits |
| ret_vld | input | 1 | Instruction with tag `ret_tag` retires |
| ret_tag | input | 3 | Tag retiring, in program order |
| flush_vld | input | 1 | Pipeline flush |
| flush_tag | input | 3 | Youngest surviving tag of the flush |
| iwp_evt | output | 4 | Instruction watchpoint events |
| lwp_evt | output | 2 | Load/store watchpoint events |
| ibrk | output | 1 | Instruction breakpoint event |
| lbrk | output | 1 | Load/store breakpoint event |
| wp_pin | output | 5 | External watchpoint pins |

## Verification
Single-term and two-term patterns exercise the first stage. A hit vector that satisfies only part of an AND term separates an AND term from a wrongly ORed one, and a vector that satisfies only the second term shows that both terms reach the output. Second-stage patterns pair instruction watchpoints with data hits that arrive over several accesses, one of them in the retire cycle, so that lost accumulation or a missing bypass is visible. Flushes around the table head tell "younger than" apart from "older than" and from an off-by-one at the flush tag. Enable and mask changes between fetch and retire show whether gating is sampled late or early. A long pipelined run with pseudo-random hits, modes and wrapping tags covers the rest.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int N_ICMP = 4;
  localparam int N_LCMP = 4;
  localparam int N_IWP  = 4;
  localparam int N_LWP  = 2;
  localparam int S1_OUT = N_IWP + 1;
  localparam int S2_IN  = N_IWP + N_LCMP;
  localparam int S2_OUT = N_LWP + 1;
  localparam int N_BRK  = 2;
  localparam int N_PIN  = 5;
endpackage

// File: rtl/wp_andor_stage.sv
module wp_andor_stage #(
  parameter int NIN   = 4,
  parameter int NOUT  = 5,
  parameter int NTERM = 2
) (
  input  logic [NIN*NTERM*NOUT-1:0] sel,
  input  logic [NIN-1:0]            hit,
  output logic [NOUT-1:0]           fire
);
  localparam int NTOT = NOUT * NTERM;

  logic [NTOT-1:0] term;

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    for (genvar t = 0; t < NTERM; t++) begin : g_term
      logic [NIN-1:0] tsel;
      assign tsel = sel[(o*NTERM+t)*NIN +: NIN];
      // An empty select disables the term.
      assign term[o*NTERM+t] = (|tsel) && ((hit & tsel) == tsel);
    end
    assign fire[o] = |term[o*NTERM +: NTERM];
  end
endmodule

// File: rtl/wp_pend_table.sv
module wp_pend_table
  import wp_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_vld,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic [N_IWP-1:0] fetch_iwp,
  input  logic             fetch_ibrk,
  input  logic             ls_vld,
  input  logic [TAG_W-1:0] ls_tag,
  input  logic [N_LCMP-1:0] ls_hit,
  input  logic             ret_vld,
  input  logic [TAG_W-1:0] ret_tag,
  input  logic             flush_vld,
  input  logic [TAG_W-1:0] flush_tag,
  output logic             rd_vld,
  output logic [N_IWP-1:0] rd_iwp,
  output logic             rd_ibrk,
  output logic [N_LCMP-1:0] rd_lsh
);
  localparam int DEPTH = 1 << TAG_W;

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [DEPTH-1:0]  ibrk_q, ibrk_d;
  logic [N_IWP-1:0]  iwp_q [DEPTH];
  logic [N_IWP-1:0]  iwp_d [DEPTH];
  logic [N_LCMP-1:0] lsh_q [DEPTH];
  logic [N_LCMP-1:0] lsh_d [DEPTH];
  logic [TAG_W-1:0]  head_q, head_d;
  logic              upd_en;

  function automatic logic [TAG_W-1:0] age_of(input logic [TAG_W-1:0] tag,
                                               input logic [TAG_W-1:0] head);
    return tag - head;
  endfunction

  assign upd_en = fetch_vld | ls_vld | ret_vld | flush_vld;

  // Next state: retire and flush clear, then fetch writes, then hits accumulate.
  always_comb begin
    vld_d  = vld_q;
    ibrk_d = ibrk_q;
    iwp_d  = iwp_q;
    lsh_d  = lsh_q;
    head_d = head_q;
    if (flush_vld) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (age_of(TAG_W'(i), head_q) > age_of(flush_tag, head_q)) begin
          vld_d[i] = 1'b0;
        end
      end
    end
    if (ret_vld) begin
      vld_d[ret_tag] = 1'b0;
      head_d         = ret_tag + TAG_W'(1);
    end
    if (fetch_vld) begin
      vld_d[fetch_tag]  = 1'b1;
      ibrk_d[fetch_tag] = fetch_ibrk;
      iwp_d[fetch_tag]  = fetch_iwp;
      lsh_d[fetch_tag]  = '0;
    end
    if (ls_vld) begin
      lsh_d[ls_tag] = lsh_d[ls_tag] | ls_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      ibrk_q <= '0;
      head_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        iwp_q[i] <= '0;
        lsh_q[i] <= '0;
      end
    end else if (upd_en) begin
      vld_q  <= vld_d;
      ibrk_q <= ibrk_d;
      head_q <= head_d;
      iwp_q  <= iwp_d;
      lsh_q  <= lsh_d;
    end
  end

  // Read port at retirement, with bypass of a same-cycle access.
  assign rd_vld  = vld_q[ret_tag];
  assign rd_iwp  = iwp_q[ret_tag];
  assign rd_ibrk = ibrk_q[ret_tag];
  assign rd_lsh  = lsh_q[ret_tag] |
                   ((ls_vld && (ls_tag == ret_tag)) ? ls_hit : '0);

  a_r4_retire_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !(fetch_vld && (fetch_tag == ret_tag))) |=> !vld_q[$past(ret_tag)]);

  a_r5_ls_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_vld && !(fetch_vld && (fetch_tag == ls_tag))) |=>
      ((lsh_q[$past(ls_tag)] & $past(ls_hit)) == $past(ls_hit)));
endmodule

// File: rtl/wp_retire_report.sv
module wp_retire_report
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_vld,
  input  logic              rd_vld,
  input  logic [N_IWP-1:0]  rd_iwp,
  input  logic              rd_ibrk,
  input  logic [S2_OUT-1:0] s2_fire,
  input  logic [N_BRK-1:0]  trap_en,
  input  logic [N_BRK-1:0]  brk_nomask,
  input  logic              core_unmasked,
  output logic [N_IWP-1:0]  iwp_evt,
  output logic [N_LWP-1:0]  lwp_evt,
  output logic              ibrk,
  output logic              lbrk
);
  logic              fire;
  logic [N_BRK-1:0]  brk_ok;
  logic [N_IWP-1:0]  iwp_d;
  logic [N_LWP-1:0]  lwp_d;
  logic              ibrk_d, lbrk_d;

  for (genvar k = 0; k < N_BRK; k++) begin : g_gate
    assign brk_ok[k] = trap_en[k] & (brk_nomask[k] | core_unmasked);
  end

  always_comb begin
    fire   = ret_vld & rd_vld;
    iwp_d  = fire ? rd_iwp : '0;
    lwp_d  = fire ? s2_fire[N_LWP-1:0] : '0;
    ibrk_d = fire & rd_ibrk & brk_ok[0];
    lbrk_d = fire & s2_fire[N_LWP] & brk_ok[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iwp_evt <= '0;
      lwp_evt <= '0;
      ibrk    <= 1'b0;
      lbrk    <= 1'b0;
    end else begin
      iwp_evt <= iwp_d;
      lwp_evt <= lwp_d;
      ibrk    <= ibrk_d;
      lbrk    <= lbrk_d;
    end
  end
endmodule

// File: rtl/wp_combiner.sv
module wp_combiner
  import wp_pkg::*;
#(
  parameter int TAG_W = 3,
  parameter int NTERM = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_ICMP*NTERM*S1_OUT-1:0] s1_sel,
  input  logic [S2_IN*NTERM*S2_OUT-1:0]  s2_sel,
  input  logic [N_BRK-1:0]              trap_en,
  input  logic [N_BRK-1:0]              brk_nomask,
  input  logic                          core_unmasked,
  input  logic                          fetch_vld,
  input  logic [TAG_W-1:0]              fetch_tag,
  input  logic [N_ICMP-1:0]             icmp_hit,
  input  logic                          ls_vld,
  input  logic [TAG_W-1:0]              ls_tag,
  input  logic [N_LCMP-1:0]             lcmp_hit,
  input  logic                          ret_vld,
  input  logic [TAG_W-1:0]              ret_tag,
  input  logic                          flush_vld,
  input  logic [TAG_W-1:0]              flush_tag,
  output logic [N_IWP-1:0]              iwp_evt,
  output logic [N_LWP-1:0]              lwp_evt,
  output logic                          ibrk,
  output logic                          lbrk,
  output logic [N_PIN-1:0]              wp_pin
);
  logic [S1_OUT-1:0] s1_fire;
  logic [S2_OUT-1:0] s2_fire;
  logic              rd_vld, rd_ibrk;
  logic [N_IWP-1:0]  rd_iwp;
  logic [N_LCMP-1:0] rd_lsh;

  wp_andor_stage #(.NIN(N_ICMP), .NOUT(S1_OUT), .NTERM(NTERM)) u_stage1 (
    .sel (s1_sel),
    .hit (icmp_hit),
    .fire(s1_fire)
  );

  wp_pend_table #(.TAG_W(TAG_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_vld (fetch_vld),
    .fetch_tag (fetch_tag),
    .fetch_iwp (s1_fire[N_IWP-1:0]),
    .fetch_ibrk(s1_fire[N_IWP]),
    .ls_vld    (ls_vld),
    .ls_tag    (ls_tag),
    .ls_hit    (lcmp_hit),
    .ret_vld   (ret_vld),
    .ret_tag   (ret_tag),
    .flush_vld (flush_vld),
    .flush_tag (flush_tag),
    .rd_vld    (rd_vld),
    .rd_iwp    (rd_iwp),
    .rd_ibrk   (rd_ibrk),
    .rd_lsh    (rd_lsh)
  );

  wp_andor_stage #(.NIN(S2_IN), .NOUT(S2_OUT), .NTERM(NTERM)) u_stage2 (
    .sel (s2_sel),
    .hit ({rd_lsh, rd_iwp}),
    .fire(s2_fire)
  );

  wp_retire_report u_report (
    .clk          (clk),
    .rst_n        (rst_n),
    .ret_vld      (ret_vld),
    .rd_vld       (rd_vld),
    .rd_iwp       (rd_iwp),
    .rd_ibrk      (rd_ibrk),
    .s2_fire      (s2_fire),
    .trap_en      (trap_en),
    .brk_nomask   (brk_nomask),
    .core_unmasked(core_unmasked),
    .iwp_evt      (iwp_evt),
    .lwp_evt      (lwp_evt),
    .ibrk         (ibrk),
    .lbrk         (lbrk)
  );

  assign wp_pin = {lwp_evt, iwp_evt[2:0]};

  a_r4_quiet_without_retire: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_vld |=> ((iwp_evt == '0) && (lwp_evt == '0) && !ibrk && !lbrk));

  a_r7_ibrk_needs_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !trap_en[0]) |=> !ibrk);

  a_r7_lbrk_needs_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !trap_en[1]) |=> !lbrk);

  a_r8_ibrk_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !brk_nomask[0] && !core_unmasked) |=> !ibrk);

  a_r8_lbrk_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !brk_nomask[1] && !core_unmasked) |=> !lbrk);
endmodule

// File: tb/sim_wp_combiner.sv
module sim_wp_combiner;
  localparam int CLK_PER = 10;
  localparam int TW      = 3;

  typedef struct packed {
    int       due;
    logic [3:0] iwp;
    logic [1:0] lwp;
    logic       ib;
    logic       lb;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [39:0] s1_sel;
  logic [47:0] s2_sel;
  logic [1:0]  trap_en, brk_nomask;
  logic        core_unmasked;
  logic        fetch_vld, ls_vld, ret_vld, flush_vld;
  logic [TW-1:0] fetch_tag, ls_tag, ret_tag, flush_tag;
  logic [3:0]  icmp_hit, lcmp_hit;
  logic [3:0]  iwp_evt;
  logic [1:0]  lwp_evt;
  logic        ibrk, lbrk;
  logic [4:0]  wp_pin;

  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   run = 0;
  bit   done = 0;
  exp_t q_exp[$];
  string q_req[$];

  // next-cycle control values, applied by the driver at its edge
  logic [1:0] t_trap = 2'b11, t_nm = 2'b11;
  logic       t_cu = 1'b0;

  // bench model of the pending table
  logic [3:0] m_iwp [8];
  logic       m_ib  [8];
  logic [3:0] m_lsh [8];
  logic       m_vld [8];
  logic [TW-1:0] m_head;

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wp_combiner u0 (
    .clk(clk), .rst_n(rst_n), .s1_sel(s1_sel), .s2_sel(s2_sel),
    .trap_en(trap_en), .brk_nomask(brk_nomask), .core_unmasked(core_unmasked),
    .fetch_vld(fetch_vld), .fetch_tag(fetch_tag), .icmp_hit(icmp_hit),
    .ls_vld(ls_vld), .ls_tag(ls_tag), .lcmp_hit(lcmp_hit),
    .ret_vld(ret_vld), .ret_tag(ret_tag), .flush_vld(flush_vld), .flush_tag(flush_tag),
    .iwp_evt(iwp_evt), .lwp_evt(lwp_evt), .ibrk(ibrk), .lbrk(lbrk), .wp_pin(wp_pin)
  );

  function automatic logic [7:0] f_ao(input logic [63:0] sel, input logic [7:0] in,
                                      input int nin, input int nout);
    logic [7:0] r;
    r = '0;
    for (int o = 0; o < nout; o++) begin
      for (int t = 0; t < 2; t++) begin
        logic [7:0] s;
        s = '0;
        for (int i = 0; i < nin; i++) s[i] = sel[(o*2+t)*nin+i];
        if (s != 0 && (in & s) == s) r[o] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [12:0] act, input logic [12:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor: pops scoreboard items when due, otherwise expects silence (R4)
  always @(negedge clk) begin
    if (run) begin
      logic [12:0] act, ex;
      string rq;
      act = {iwp_evt, lwp_evt, ibrk, lbrk, wp_pin};
      if (q_exp.size() > 0 && q_exp[0].due == cyc) begin
        exp_t e;
        e = q_exp.pop_front();
        rq = q_req.pop_front();
        ex = {e.iwp, e.lwp, e.ib, e.lb, e.lwp, e.iwp[2:0]};
      end else begin
        ex = '0;
        rq = "R4 quiet";
      end
      chk(act == ex, rq, act, ex);
    end
  end

  // one cycle of stimulus; model updated in the order retire-read, flush, retire, fetch, ls
  task automatic step(input bit fv, input logic [TW-1:0] ft, input logic [3:0] fh,
                      input bit lv, input logic [TW-1:0] lt, input logic [3:0] lh,
                      input bit rv, input logic [TW-1:0] rt,
                      input bit xv, input logic [TW-1:0] xt, input string req);
    @(negedge clk);
    fetch_vld = fv; fetch_tag = ft; icmp_hit = fh;
    ls_vld = lv; ls_tag = lt; lcmp_hit = lh;
    ret_vld = rv; ret_tag = rt;
    flush_vld = xv; flush_tag = xt;
    trap_en = t_trap; brk_nomask = t_nm; core_unmasked = t_cu;
    if (rv) begin
      exp_t e;
      logic [3:0] lsh;
      logic [7:0] s2;
      logic [1:0] ok;
      lsh = m_lsh[rt] | ((lv && lt == rt) ? lh : 4'b0);
      s2 = f_ao({16'b0, s2_sel}, {lsh, m_iwp[rt]}, 8, 3);
      ok = t_trap & (t_nm | {2{t_cu}});
      e.due = cyc + 1;
      e.iwp = m_vld[rt] ? m_iwp[rt] : 4'b0;
      e.lwp = m_vld[rt] ? s2[1:0] : 2'b0;
      e.ib  = m_vld[rt] & m_ib[rt] & ok[0];
      e.lb  = m_vld[rt] & s2[2] & ok[1];
      q_exp.push_back(e);
      q_req.push_back(req);
    end
    if (xv) begin
      for (int i = 0; i < 8; i++)
        if (TW'(TW'(i) - m_head) > TW'(xt - m_head)) m_vld[i] = 1'b0;
    end
    if (rv) begin
      m_vld[rt] = 1'b0;
      m_head = rt + TW'(1);
    end
    if (fv) begin
      logic [7:0] s1;
      s1 = f_ao({24'b0, s1_sel}, {4'b0, fh}, 4, 5);
      m_vld[ft] = 1'b1; m_iwp[ft] = s1[3:0]; m_ib[ft] = s1[4]; m_lsh[ft] = 4'b0;
    end
    if (lv) m_lsh[lt] = m_lsh[lt] | lh;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic fetch(input logic [TW-1:0] t, input logic [3:0] h);
    step(1, t, h, 0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic ldst(input logic [TW-1:0] t, input logic [3:0] h);
    step(0, 0, 0, 1, t, h, 0, 0, 0, 0, "");
  endtask
  task automatic retire(input logic [TW-1:0] t, input string req);
    step(0, 0, 0, 0, 0, 0, 1, t, 0, 0, req);
  endtask

  function automatic void s1_set(int o, int t, int i);
    s1_sel[(o*2+t)*4+i] = 1'b1;
  endfunction
  function automatic void s2_set(int o, int t, int i);
    s2_sel[(o*2+t)*8+i] = 1'b1;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [TW-1:0] base;
    rst_n = 1'b0;
    s1_sel = '0; s2_sel = '0; trap_en = 2'b11; brk_nomask = 2'b11; core_unmasked = 1'b0;
    fetch_vld = 0; fetch_tag = 0; icmp_hit = 0; ls_vld = 0; ls_tag = 0; lcmp_hit = 0;
    ret_vld = 0; ret_tag = 0; flush_vld = 0; flush_tag = 0;
    for (int i = 0; i < 8; i++) begin
      m_vld[i] = 0; m_iwp[i] = 0; m_ib[i] = 0; m_lsh[i] = 0;
    end
    m_head = '0;
    // stage 1: iwp0=h0, iwp1=h1&h2, iwp2=h3|(h0&h1), iwp3=h2, ibrk=h0&h3
    s1_set(0,0,0); s1_set(1,0,1); s1_set(1,0,2); s1_set(2,0,3); s1_set(2,1,0); s1_set(2,1,1);
    s1_set(3,0,2); s1_set(4,0,0); s1_set(4,0,3);
    // stage 2: lwp0=iwp0&ls0, lwp1=ls2&ls3, lbrk=ls3|(iwp3&ls0)
    s2_set(0,0,0); s2_set(0,0,4); s2_set(1,0,6); s2_set(1,0,7);
    s2_set(2,0,7); s2_set(2,1,3); s2_set(2,1,4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk({iwp_evt, lwp_evt, ibrk, lbrk, wp_pin} == '0, "R1 reset",
        {iwp_evt, lwp_evt, ibrk, lbrk, wp_pin}, '0);
    run = 1;

    // R2 / R9: first-stage patterns
    fetch(0, 4'b0001); idle(1); retire(0, "R2 single term");
    fetch(1, 4'b1001); retire(1, "R2 two outputs + ibrk");
    fetch(2, 4'b0110); retire(2, "R2 AND term full");
    fetch(3, 4'b0011); retire(3, "R9 second term only");
    // R3 / R5: second stage and accumulation
    fetch(4, 4'b0001); ldst(4, 4'b0001); retire(4, "R3 iwp qualifies ls");
    fetch(5, 4'b0000); ldst(5, 4'b0100); ldst(5, 4'b1000); retire(5, "R5 accumulate");
    fetch(6, 4'b0000); step(0, 0, 0, 1, 6, 4'b1000, 1, 6, 0, 0, "R5 same-cycle access");
    fetch(7, 4'b0100); ldst(7, 4'b0001); retire(7, "R3 second term lbrk");
    fetch(0, 4'b0001); ldst(0, 4'b0100); retire(0, "R3 partial AND");
    // R6: flush
    fetch(1, 4'b0001); fetch(2, 4'b0001); fetch(3, 4'b0001); fetch(4, 4'b0001);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, "");
    retire(1, "R6 older kept"); retire(2, "R6 flush tag kept");
    retire(3, "R6 dropped"); retire(4, "R6 dropped");
    fetch(5, 4'b1001); retire(5, "R6 refetch live");
    // R7 / R10: trap enable changed between fetch and retire
    fetch(6, 4'b1001); ldst(6, 4'b1000);
    t_trap = 2'b00; retire(6, "R7 R10 trap off");
    t_trap = 2'b11; fetch(7, 4'b1001); ldst(7, 4'b1000); retire(7, "R7 trap on");
    t_trap = 2'b01; fetch(0, 4'b1001); ldst(0, 4'b1000); retire(0, "R7 split enable");
    // R8: masking
    t_trap = 2'b11; t_nm = 2'b00; t_cu = 1'b0;
    fetch(1, 4'b1001); ldst(1, 4'b1000); retire(1, "R8 masked blocked");
    fetch(2, 4'b1001); ldst(2, 4'b1000); t_cu = 1'b1; retire(2, "R8 masked allowed");
    t_nm = 2'b11; t_cu = 1'b0;
    fetch(3, 4'b1001); ldst(3, 4'b1000); retire(3, "R8 nonmasked");
    idle(2);
    // pipelined pseudo-random run with wrapping tags
    lf = 16'hACE1;
    base = m_head;
    for (int i = 0; i < 400; i++) begin
      bit fv, lv, rv;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      t_trap = lf[1:0]; t_nm = lf[3:2]; t_cu = lf[4];
      fv = (i < 396);
      lv = (i >= 1) && (i < 397);
      rv = (i >= 3) && (i < 399);
      step(fv, base + TW'(i), lf[8:5], lv, base + TW'(i - 1), lf[12:9],
           rv, base + TW'(i - 3), 0, 0, "R2 R3 R10 pipelined");
    end
    idle(3);
    run = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule